// File: doc/BRIEF.md
# Card Byte/Word Transfer Engine

This block sits between a host that reads and writes 32-bit words and a storage card whose data port carries one byte at a time. A one-cycle start pulse arms a transfer of a given byte length in a chosen direction. From that point the engine runs two counters: one counts the card bytes still to move, the other counts the host words still to be exchanged. It keeps a 16-entry circular word buffer between the two sides.

When data comes from the card, incoming bytes are gathered four at a time into a word, least significant byte first, and pushed into the buffer. A short final group is pushed with its unused upper bytes at zero. When data goes to the card, words that the host has written are split into bytes, lowest byte first, and sent one per clock. Either side stalls when the buffer cannot serve it. Five buffer status flags are shown for the active direction only. Two sticky end flags go high once the byte counter runs out. The engine disarms itself once both counters are exhausted.

Top module: `card_xfer_engine`

## Requirements
- R1: After reset the engine is disarmed: `xfer_enable`, `data_end`, `block_end`, `host_rd_data`, both flag groups, `card_rx_take` and `card_tx_valid` are all zero.
- R2: A `xfer_start` pulse arms the engine on the next cycle (`xfer_enable`=1), loads the byte counter with `xfer_len` and the host word counter with ceil(`xfer_len`/4), and clears the end flags. Such a transfer moves exactly `xfer_len` card bytes and exactly ceil(`xfer_len`/4) host words.
- R3: With `xfer_dir`=1 (card to host), card byte i lands in bits 8*(i mod 4)+7 : 8*(i mod 4) of host word i/4. Words leave the buffer in arrival order across pointer wrap. A byte is taken (`card_rx_take`=1) only in a cycle where `card_rx_valid`=1 and the buffer holds fewer than 16 words.
- R4: In the card-to-host direction, a final group of 1 to 3 bytes is pushed as a word whose remaining upper bytes are zero.
- R5: With `xfer_dir`=0 (host to card), each buffered word is sent as four bytes, bits 7:0 first, one byte per clock on `card_tx_data` with `card_tx_valid`=1. Sending pauses while the buffer is empty.
- R6: When the byte counter reaches zero while armed, `data_end` and `block_end` go to 1 on the next cycle and stay at 1 until the next start.
- R7: When both counters are zero, every flag bit drops in that cycle and `xfer_enable` returns to 0 on the next clock.
- R8: Flag bits are [0] active, [1] empty (0 words), [2] data available (1 or more), [3] full (16), [4] half mark. The half mark means 8 or fewer words in `tx_flags` and 8 or more in `rx_flags`. Only `tx_flags` is nonzero in the host-to-card direction, only `rx_flags` in the other, and both are zero when disarmed.
- R9: A host access is ignored when the word counter is zero, the engine is disarmed, the access goes against the direction, or the buffer cannot serve it. An ignored read returns 0 on `host_rd_data` on the following cycle. An accepted read returns the oldest word there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | One-cycle pulse that arms a transfer |
| xfer_len | input | 16 | Transfer length in bytes, sampled with `xfer_start` |
| xfer_dir | input | 1 | 1 = card to host, 0 = host to card, sampled with `xfer_start` |
| host_wr_en | input | 1 | Host word write request |
| host_wr_data | input | 32 | Host write word |
| host_rd_en | input | 1 | Host word read request |
| host_rd_data | output | 32 | Read word, valid the cycle after `host_rd_en` |
| card_rx_valid | input | 1 | Card has a byte ready |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_take | output | 1 | Engine consumes `card_rx_data` this cycle |
| card_tx_valid | output | 1 | Engine sends `card_tx_data` this cycle |
| card_tx_data | output | 8 | Byte to the card |
| xfer_enable | output | 1 | Engine armed |
| data_end | output | 1 | Byte counter exhausted (sticky) |
| block_end | output | 1 | Block finished (sticky, same timing as `data_end`) |
| tx_flags | output | 5 | Buffer flags for the host-to-card direction |
| rx_flags | output | 5 | Buffer flags for the card-to-host direction |

## Verification
The hardest states to reach are the buffer threshold and full states in the card-to-host direction, where the stall must come from the buffer and not from the card. The bench gets there by holding off host reads for a fixed number of cycles after start while the card keeps supplying bytes. Lengths of 28, 32 and 100 bytes park exactly 7, 8 and 16 words, and the flag word is compared against the value computed from that count. The long runs then drain through the pointer wrap. Lengths 0 to 20 in both directions cover every partial final group. A write run with sparse host writes starves the byte sender between words. A read run with the host writing throughout, and a read after completion, probe the ignored accesses.

// File: rtl/card_xfer_pkg.sv
package card_xfer_pkg;

   localparam int FLG_ACTIVE = 0;
   localparam int FLG_EMPTY  = 1;
   localparam int FLG_AVAIL  = 2;
   localparam int FLG_FULL   = 3;
   localparam int FLG_HALF   = 4;
   localparam int FLG_W      = 5;

   typedef enum logic {
      DIR_TO_CARD   = 1'b0,
      DIR_FROM_CARD = 1'b1
   } xfer_dir_e;

endpackage

// File: rtl/card_xfer_fifo.sv
module card_xfer_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 16,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     push_data,
   input  logic             pop,
   output logic [W-1:0]     head,
   output logic [CNT_W-1:0] count
);
   localparam int PTR_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("card_xfer_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]     mem_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (push) mem_q[wr_ptr_q] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
         if (pop)  rd_ptr_q <= rd_ptr_q + PTR_W'(1);
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign head  = mem_q[rd_ptr_q];
   assign count = cnt_q;
endmodule

// File: rtl/card_xfer_pack.sv
module card_xfer_pack #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         go,
   input  logic         last,
   input  logic         rx_valid,
   input  logic [7:0]   rx_byte,
   input  logic         fifo_full,
   output logic         take,
   output logic         push,
   output logic [W-1:0] word
);
   localparam int LANES   = W / 8;
   localparam int LANE_SH = $clog2(LANES);

   logic [W-1:0]       acc_q;
   logic [W-1:0]       merged;
   logic [LANE_SH-1:0] lane_q;
   logic               wrap;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[l*8 +: 8] = (lane_q == LANE_SH'(l)) ? rx_byte : acc_q[l*8 +: 8];
   end

   assign take = go && rx_valid && !fifo_full;
   assign wrap = (lane_q == LANE_SH'(LANES - 1));
   assign push = take && (wrap || last);
   assign word = merged;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         lane_q <= '0;
      end else if (clear) begin
         acc_q  <= '0;
         lane_q <= '0;
      end else if (take) begin
         if (push) begin
            acc_q  <= '0;
            lane_q <= '0;
         end else begin
            acc_q  <= merged;
            lane_q <= lane_q + LANE_SH'(1);
         end
      end
   end
endmodule

// File: rtl/card_xfer_unpack.sv
module card_xfer_unpack #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         go,
   input  logic         fifo_empty,
   input  logic [W-1:0] head,
   output logic         emit,
   output logic         pop,
   output logic [7:0]   tx_byte
);
   localparam int LANES   = W / 8;
   localparam int LEFT_W  = $clog2(LANES) + 1;

   logic [W-1:0]      hold_q;
   logic [LEFT_W-1:0] left_q;
   logic              have_left;

   assign have_left = (left_q != '0);
   assign pop       = go && !have_left && !fifo_empty;
   assign emit      = go && (have_left || !fifo_empty);
   assign tx_byte   = have_left ? hold_q[7:0] : head[7:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         left_q <= '0;
      end else if (clear) begin
         hold_q <= '0;
         left_q <= '0;
      end else if (pop) begin
         hold_q <= head >> 8;
         left_q <= LEFT_W'(LANES - 1);
      end else if (emit) begin
         hold_q <= hold_q >> 8;
         left_q <= left_q - LEFT_W'(1);
      end
   end
endmodule

// File: rtl/card_xfer_engine.sv
module card_xfer_engine
   import card_xfer_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int FIFO_DEPTH = 16,
   parameter int LEN_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_start,
   input  logic [LEN_W-1:0]  xfer_len,
   input  logic              xfer_dir,
   input  logic              host_wr_en,
   input  logic [DATA_W-1:0] host_wr_data,
   input  logic              host_rd_en,
   output logic [DATA_W-1:0] host_rd_data,
   input  logic              card_rx_valid,
   input  logic [7:0]        card_rx_data,
   output logic              card_rx_take,
   output logic              card_tx_valid,
   output logic [7:0]        card_tx_data,
   output logic              xfer_enable,
   output logic              data_end,
   output logic              block_end,
   output logic [FLG_W-1:0]  tx_flags,
   output logic [FLG_W-1:0]  rx_flags
);
   localparam int LANES   = DATA_W / 8;
   localparam int LANE_SH = $clog2(LANES);
   localparam int WC_W    = LEN_W - LANE_SH + 1;
   localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);
   localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(FIFO_DEPTH / 2);

   if (DATA_W < 16 || (DATA_W % 8) != 0 || (LANES & (LANES - 1)) != 0) begin : g_bad_width
      $error("card_xfer_engine: DATA_W must be a power-of-two count of bytes, at least 2");
   end
   if (LEN_W <= LANE_SH) begin : g_bad_len
      $error("card_xfer_engine: LEN_W too small for the word size");
   end

   logic              en_q;
   xfer_dir_e         dir_q;
   logic [LEN_W-1:0]  byte_cnt_q;
   logic [WC_W-1:0]   word_cnt_q;
   logic              end_q;
   logic [DATA_W-1:0] rd_data_q;

   logic [LEN_W:0]    len_pad;
   logic [WC_W-1:0]   words_of_len;
   logic              bytes_left, words_left, done, live;
   logic              to_card, from_card;

   logic [DATA_W-1:0] fifo_head, fifo_in;
   logic [CNT_W-1:0]  fifo_count;
   logic              fifo_full, fifo_empty, fifo_push, fifo_pop;
   logic              host_wr_ok, host_rd_ok;

   logic              pk_take, pk_push;
   logic [DATA_W-1:0] pk_word;
   logic              up_emit, up_pop;
   logic [7:0]        up_byte;

   assign len_pad      = {1'b0, xfer_len} + (LEN_W + 1)'(LANES - 1);
   assign words_of_len = len_pad[LEN_W:LANE_SH];

   assign bytes_left = (byte_cnt_q != '0);
   assign words_left = (word_cnt_q != '0);
   assign done       = !bytes_left && !words_left;
   assign live       = en_q && !done;
   assign from_card  = en_q && (dir_q == DIR_FROM_CARD);
   assign to_card    = en_q && (dir_q == DIR_TO_CARD);

   assign fifo_full  = (fifo_count == FULL_CNT);
   assign fifo_empty = (fifo_count == '0);

   assign host_wr_ok = host_wr_en && to_card   && words_left && !fifo_full;
   assign host_rd_ok = host_rd_en && from_card && words_left && !fifo_empty;

   card_xfer_pack #(.W(DATA_W)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (xfer_start),
      .go        (from_card && bytes_left),
      .last      (byte_cnt_q == LEN_W'(1)),
      .rx_valid  (card_rx_valid),
      .rx_byte   (card_rx_data),
      .fifo_full (fifo_full),
      .take      (pk_take),
      .push      (pk_push),
      .word      (pk_word)
   );

   card_xfer_unpack #(.W(DATA_W)) u_unpack (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (xfer_start),
      .go         (to_card && bytes_left),
      .fifo_empty (fifo_empty),
      .head       (fifo_head),
      .emit       (up_emit),
      .pop        (up_pop),
      .tx_byte    (up_byte)
   );

   assign fifo_push = (dir_q == DIR_FROM_CARD) ? pk_push : host_wr_ok;
   assign fifo_in   = (dir_q == DIR_FROM_CARD) ? pk_word : host_wr_data;
   assign fifo_pop  = (dir_q == DIR_FROM_CARD) ? host_rd_ok : up_pop;

   card_xfer_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (fifo_push),
      .push_data (fifo_in),
      .pop       (fifo_pop),
      .head      (fifo_head),
      .count     (fifo_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= 1'b0;
         dir_q      <= DIR_TO_CARD;
         byte_cnt_q <= '0;
         word_cnt_q <= '0;
         end_q      <= 1'b0;
      end else if (xfer_start) begin
         en_q       <= 1'b1;
         dir_q      <= xfer_dir_e'(xfer_dir);
         byte_cnt_q <= xfer_len;
         word_cnt_q <= words_of_len;
         end_q      <= 1'b0;
      end else begin
         if (en_q && done) en_q <= 1'b0;
         if (pk_take || up_emit) byte_cnt_q <= byte_cnt_q - LEN_W'(1);
         if (host_wr_ok || host_rd_ok) word_cnt_q <= word_cnt_q - WC_W'(1);
         if (en_q && !bytes_left) end_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rd_data_q <= '0;
      else if (host_rd_en) rd_data_q <= host_rd_ok ? fifo_head : '0;
   end

   always_comb begin
      logic [FLG_W-1:0] base;
      base             = '0;
      base[FLG_ACTIVE] = 1'b1;
      base[FLG_EMPTY]  = fifo_empty;
      base[FLG_AVAIL]  = !fifo_empty;
      base[FLG_FULL]   = fifo_full;
      tx_flags         = '0;
      rx_flags         = '0;
      if (live && dir_q == DIR_TO_CARD) begin
         tx_flags           = base;
         tx_flags[FLG_HALF] = (fifo_count <= HALF_CNT);
      end
      if (live && dir_q == DIR_FROM_CARD) begin
         rx_flags           = base;
         rx_flags[FLG_HALF] = (fifo_count >= HALF_CNT);
      end
   end

   assign host_rd_data  = rd_data_q;
   assign card_rx_take  = pk_take;
   assign card_tx_valid = up_emit;
   assign card_tx_data  = up_byte;
   assign xfer_enable   = en_q;
   assign data_end      = end_q;
   assign block_end     = end_q;
endmodule

// File: rtl/card_xfer_engine_chk.sv
module card_xfer_engine_chk
   import card_xfer_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int FIFO_DEPTH = 16,
   parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              xfer_start,
   input logic              host_rd_en,
   input logic [DATA_W-1:0] host_rd_data,
   input logic              card_rx_valid,
   input logic              card_rx_take,
   input logic              card_tx_valid,
   input logic              xfer_enable,
   input logic              data_end,
   input logic [FLG_W-1:0]  tx_flags,
   input logic [FLG_W-1:0]  rx_flags,
   input logic [CNT_W-1:0]  fifo_count
);
   // R2: a start pulse arms the engine
   a_r2_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> xfer_enable);

   // R3: bytes taken only when offered and the buffer has room
   a_r3_take_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      card_rx_take |-> card_rx_valid);
   a_r3_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_count == CNT_W'(FIFO_DEPTH)) |-> !card_rx_take);

   // R5: only one card direction moves per cycle
   a_r5_one_card_side: assert property (@(posedge clk) disable iff (!rst_n)
      !(card_tx_valid && card_rx_take));

   // R6: end flag sticky until restart
   a_r6_end_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (data_end && !xfer_start) |=> data_end);

   // R7: disarming only after the byte counter has run out
   a_r7_end_before_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xfer_enable) |-> data_end);

   // R8: flag groups exclusive, full and empty exclusive
   a_r8_one_group: assert property (@(posedge clk) disable iff (!rst_n)
      !((|tx_flags) && (|rx_flags)));
   a_r8_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flags[FLG_FULL] |-> !rx_flags[FLG_EMPTY]);

   // R9: reads while disarmed return zero
   a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd_en && !xfer_enable) |=> (host_rd_data == '0));
endmodule

bind card_xfer_engine card_xfer_engine_chk #(
   .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start),
   .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
   .card_rx_valid(card_rx_valid), .card_rx_take(card_rx_take),
   .card_tx_valid(card_tx_valid), .xfer_enable(xfer_enable),
   .data_end(data_end), .tx_flags(tx_flags), .rx_flags(rx_flags),
   .fifo_count(fifo_count)
);

// File: tb/card_xfer_engine_bench.sv
module card_xfer_engine_bench;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfer_start = 1'b0;
   logic [15:0] xfer_len = '0;
   logic        xfer_dir = 1'b0;
   logic        host_wr_en = 1'b0;
   logic [31:0] host_wr_data = '0;
   logic        host_rd_en = 1'b0;
   logic [31:0] host_rd_data;
   logic        card_rx_valid = 1'b0;
   logic [7:0]  card_rx_data = '0;
   logic        card_rx_take;
   logic        card_tx_valid;
   logic [7:0]  card_tx_data;
   logic        xfer_enable, data_end, block_end;
   logic [4:0]  tx_flags, rx_flags;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   card_xfer_engine u_card_xfer_engine (
      .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_len(xfer_len),
      .xfer_dir(xfer_dir), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
      .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
      .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data),
      .card_rx_take(card_rx_take), .card_tx_valid(card_tx_valid),
      .card_tx_data(card_tx_data), .xfer_enable(xfer_enable),
      .data_end(data_end), .block_end(block_end),
      .tx_flags(tx_flags), .rx_flags(rx_flags)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] rpat(int len, int i);
      return 8'(i * 37 + len * 11 + 5);
   endfunction

   function automatic logic [31:0] rword(int len, int k);
      logic [31:0] w = '0;
      for (int b = 0; b < 4; b++)
         if (4 * k + b < len) w[8*b +: 8] = rpat(len, 4 * k + b);
      return w;
   endfunction

   function automatic logic [31:0] wpat(int len, int k);
      return 32'(k * 32'h0103_0507) ^ 32'hA5C3_1F00 ^ 32'(len);
   endfunction

   task automatic arm(input int len, input bit dir);
      @(negedge clk);
      xfer_start = 1'b1; xfer_len = 16'(len); xfer_dir = dir;
      @(negedge clk);
      xfer_start = 1'b0;
   endtask

   // card-to-host run; host reads held off for 'hold' cycles
   task automatic run_read(input int len, input int hold, input int exp_flags, input bit junk);
      int nw = (len + 3) / 4;
      int idx = 0, got = 0, cyc = 0;
      bit pend = 0;
      arm(len, 1'b1);
      while (cyc < 5000) begin
         if (pend) begin
            check(host_rd_data == rword(len, got), "R3", "read word (R4 tail)",
                  host_rd_data, rword(len, got));
            got++;
            pend = 0;
         end
         if (!xfer_enable) break;
         if (hold > 0 && cyc == hold - 1 && exp_flags >= 0) begin
            check(rx_flags == 5'(exp_flags), "R8", "rx flags at hold", rx_flags, exp_flags);
            check(tx_flags == 5'b0, "R8", "tx group hidden", tx_flags, 0);
         end
         card_rx_valid = ((cyc % 3) != 2);
         card_rx_data  = rpat(len, idx);
         host_rd_en    = (cyc >= hold) && rx_flags[2];
         host_wr_en    = junk;
         host_wr_data  = 32'hDEAD_BEEF;
         #1;
         if (card_rx_take) idx++;
         pend = host_rd_en;
         @(negedge clk);
         cyc++;
      end
      card_rx_valid = 1'b0; host_rd_en = 1'b0; host_wr_en = 1'b0;
      check(got == nw, "R2", "host words moved", got, nw);
      check(idx == len, "R2", "card bytes taken", idx, len);
      check(data_end && block_end, "R6", "end flags", {data_end, block_end}, 3);
      check(rx_flags == 0 && tx_flags == 0 && !xfer_enable, "R7", "idle after done",
            {xfer_enable, rx_flags, tx_flags}, 0);
   endtask

   // host-to-card run; host writes every 'gap' cycles
   task automatic run_write(input int len, input int gap);
      int nw = (len + 3) / 4;
      int idx = 0, sent = 0, cyc = 0;
      logic [31:0] w;
      arm(len, 1'b0);
      if (len > 0) begin
         check(tx_flags == 5'b10011, "R8", "tx flags at start", tx_flags, 5'b10011);
         check(rx_flags == 5'b0, "R8", "rx group hidden", rx_flags, 0);
      end
      while (cyc < 5000) begin
         if (!xfer_enable) break;
         host_wr_en   = (sent < nw) && !tx_flags[3] && ((cyc % gap) == 0);
         host_wr_data = wpat(len, sent);
         #1;
         if (card_tx_valid) begin
            w = wpat(len, idx / 4);
            check(card_tx_data == w[8*(idx%4) +: 8], "R5", "card byte",
                  card_tx_data, w[8*(idx%4) +: 8]);
            idx++;
         end
         if (host_wr_en) sent++;
         @(negedge clk);
         cyc++;
      end
      host_wr_en = 1'b0;
      check(idx == len, "R5", "card bytes sent", idx, len);
      check(sent == nw, "R2", "host words written", sent, nw);
      check(data_end && block_end, "R6", "end flags", {data_end, block_end}, 3);
      check(rx_flags == 0 && tx_flags == 0 && !xfer_enable, "R7", "idle after done",
            {xfer_enable, rx_flags, tx_flags}, 0);
   endtask

   initial begin
      #(5.0 * 190000);
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      card_rx_valid = 1'b1;
      @(negedge clk);
      #1;
      check(!xfer_enable && !data_end && !block_end, "R1", "control after reset",
            {xfer_enable, data_end, block_end}, 0);
      check(tx_flags == 0 && rx_flags == 0, "R1", "flags after reset", {tx_flags, rx_flags}, 0);
      check(host_rd_data == 0, "R1", "read data after reset", host_rd_data, 0);
      check(!card_rx_take && !card_tx_valid, "R1", "card side after reset",
            {card_rx_take, card_tx_valid}, 0);
      card_rx_valid = 1'b0;

      for (int len = 0; len <= 20; len++) run_read(len, 0, -1, 1'b0);
      run_read(63, 0, -1, 1'b0);
      run_read(64, 0, -1, 1'b0);
      run_read(65, 0, -1, 1'b0);
      run_read(28, 120, 5'b00101, 1'b0);
      run_read(32, 120, 5'b10101, 1'b0);
      run_read(100, 120, 5'b11101, 1'b0);
      // R9: host writes against the direction must not reach the buffer
      run_read(6, 0, -1, 1'b1);

      // R9: read after completion returns zero
      @(negedge clk);
      host_rd_en = 1'b1;
      @(negedge clk);
      host_rd_en = 1'b0;
      check(host_rd_data == 0, "R9", "ignored read data", host_rd_data, 0);

      for (int len = 0; len <= 20; len++) run_write(len, 1);
      run_write(13, 5);
      run_write(64, 3);
      run_write(65, 1);
      run_write(70, 7);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule